// File: doc/BRIEF.md
# MSI Source Decoder

This block sits at the front of a message-signalled interrupt controller. It takes an inbound MSI write, made of a 64-bit address, a 16-bit data word and an optional requester partition number, and turns it into a source index. The index is checked against the number of sources that are configured. When a partition number comes with the write, the block fetches that source's vector-table entry over a simple read port and compares the owner partition stored there with the requester. Only a request that passes every check produces a one-cycle interrupt pulse toward the dispatcher. The pulse carries both the local source index and the global interrupt number, which is the configured base plus the index.

A second entry point is a direct-injection write. The written value is used as the address, with data zero and no ownership check. After the injection, the block drops its injection lock flag. Rejected requests raise a one-cycle error pulse instead of an interrupt. Out-of-range requests and ownership mismatches each have their own pulse.

Top module: `msi_src_decoder`

## Requirements
- R1: The source index is address bits [19:4] bitwise-ORed with data bits [4:0]. All other address and data bits are ignored.
- R2: A request whose index is greater than or equal to the configured source count produces no interrupt. It produces an `errOob` pulse in the cycle after acceptance, and it never starts a table read.
- R3: A configuration write stores the base and the source count, with the count clamped to `MAX_SRC`. After reset the count is 0, so every request is out of range until a configuration write arrives.
- R4: An in-range request without a partition number gives `irqPulse` high for one cycle, in the cycle after acceptance. In that cycle `irqSrc` is the index and `irqNum` is base plus index.
- R5: An in-range request with a partition number gives a one-cycle `rdReq` pulse in the cycle after acceptance, with `rdIdx` equal to the index. `reqReady` and `injReady` stay low until `rdValid` returns.
- R6: If `rdPe` equals the requester partition when `rdValid` arrives, `irqPulse` rises in the following cycle. On a mismatch, `errPe` pulses instead and no interrupt is raised.
- R7: An injection forms its index from the written value with data 0 and never reads the table. It raises `irqPulse` if the index is in range, or `errOob` if it is not. In both cases it clears `injLock` in the cycle after acceptance.
- R8: An injection is accepted only while no table read is pending. While `injValid` is high, `reqReady` is low, so an injection takes priority over a request in the same cycle.
- R9: `lockSet` sets `injLock` to 1. Reset clears `injLock`, `irqPulse`, `errOob`, `errPe` and `rdReq`.
- R10: A `rdValid` that arrives while no read is pending is ignored. It produces neither `irqPulse` nor `errPe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Load base and source count |
| cfgBase | input | BASE_W | Global number of source 0 |
| cfgCount | input | CFG_W | Requested source count (clamped) |
| reqValid | input | 1 | MSI write present |
| reqReady | output | 1 | MSI write can be accepted |
| reqAddr | input | 64 | MSI address |
| reqData | input | 16 | MSI data |
| reqPeValid | input | 1 | Requester partition supplied |
| reqPe | input | PE_W | Requester partition number |
| injValid | input | 1 | Direct-injection write |
| injReady | output | 1 | Injection can be accepted |
| injValue | input | 64 | Injection value used as address |
| lockSet | input | 1 | Set the injection lock |
| injLock | output | 1 | Injection lock flag |
| rdReq | output | 1 | Vector-entry read strobe |
| rdIdx | output | 16 | Index of the entry to read |
| rdValid | input | 1 | Read data present |
| rdPe | input | PE_W | Owner partition from the entry |
| irqPulse | output | 1 | Accepted interrupt strobe |
| irqSrc | output | 16 | Local source index |
| irqNum | output | BASE_W | Base plus source index |
| errOob | output | 1 | Index out of range |
| errPe | output | 1 | Partition mismatch |

## Verification
The bench builds the block with `MAX_SRC` set to 64, which keeps the out-of-range boundary at index 64. At that size, the address-only indices 63 and 64 and an over-large configured count are all easy to reach, so the clamp can be observed. The base is set to 0x100, so `irqNum` differs visibly from `irqSrc`. The defaults of `PE_W` and `BASE_W` are kept, since partition matching and base addition do not depend on their width.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;

  localparam int SRC_IDX_W = 16;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // latch the selected index and partition
    logic useInj;    // index comes from the injection value
    logic emitIrq;   // raise the interrupt pulse
    logic emitOob;   // raise the out-of-range error
    logic emitPeErr; // raise the partition mismatch error
    logic issueRd;   // start a vector-entry read
    logic dropLock;  // clear the injection lock
  } ctl_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } dec_state_e;

  function automatic logic [SRC_IDX_W-1:0] formIndex(input logic [63:0] addr,
                                                      input logic [15:0] data);
    formIndex = addr[19:4] | {11'b0, data[4:0]};
  endfunction

endpackage

// File: rtl/msi_dec_ctrl.sv
module msi_dec_ctrl
  import msi_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqPeValid,
  input  logic        injValid,
  input  logic        rdValid,
  input  logic        newInRange,
  input  logic        peMatch,
  output logic        reqReady,
  output logic        injReady,
  output ctl_strobe_t strobe
);

  dec_state_e state, stateNext;
  logic injAccept, reqAccept;

  assign injReady  = (state == ST_IDLE);
  assign reqReady  = (state == ST_IDLE) && !injValid;
  assign injAccept = injValid && injReady;
  assign reqAccept = reqValid && reqReady;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (injAccept) begin
          strobe.capture  = 1'b1;
          strobe.useInj   = 1'b1;
          strobe.dropLock = 1'b1;
          strobe.emitIrq  = newInRange;
          strobe.emitOob  = !newInRange;
        end else if (reqAccept) begin
          strobe.capture = 1'b1;
          if (!newInRange) begin
            strobe.emitOob = 1'b1;
          end else if (!reqPeValid) begin
            strobe.emitIrq = 1'b1;
          end else begin
            strobe.issueRd = 1'b1;
            stateNext      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (rdValid) begin
          strobe.emitIrq   = peMatch;
          strobe.emitPeErr = !peMatch;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/msi_dec_dp.sv
module msi_dec_dp
  import msi_dec_pkg::*;
#(
  parameter int MAX_SRC = 2048,
  parameter int PE_W    = 8,
  parameter int BASE_W  = 24,
  parameter int CFG_W   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          strobe,
  input  logic                 cfgWrite,
  input  logic [BASE_W-1:0]    cfgBase,
  input  logic [CFG_W-1:0]     cfgCount,
  input  logic [63:0]          reqAddr,
  input  logic [15:0]          reqData,
  input  logic [PE_W-1:0]      reqPe,
  input  logic [63:0]          injValue,
  input  logic                 lockSet,
  input  logic [PE_W-1:0]      rdPe,
  output logic                 newInRange,
  output logic                 peMatch,
  output logic                 injLock,
  output logic                 rdReq,
  output logic [SRC_IDX_W-1:0] rdIdx,
  output logic                 irqPulse,
  output logic [SRC_IDX_W-1:0] irqSrc,
  output logic [BASE_W-1:0]    irqNum,
  output logic                 errOob,
  output logic                 errPe
);

  localparam int CNT_W = $clog2(MAX_SRC + 1);
  localparam int CMP_W = (CNT_W > SRC_IDX_W) ? CNT_W : SRC_IDX_W;

  logic [CNT_W-1:0]     srcCount;
  logic [BASE_W-1:0]    srcBase;
  logic [SRC_IDX_W-1:0] selIdx, heldIdx, outIdx;
  logic [PE_W-1:0]      heldPe;
  logic [CNT_W-1:0]     clampedCount;

  assign selIdx = strobe.useInj ? formIndex(injValue, 16'h0000)
                                : formIndex(reqAddr, reqData);

  assign newInRange = CMP_W'(selIdx) < CMP_W'(srcCount);
  assign peMatch    = (rdPe == heldPe);
  assign outIdx     = strobe.capture ? selIdx : heldIdx;
  assign rdIdx      = heldIdx;

  assign clampedCount = (cfgCount > CFG_W'(MAX_SRC)) ? CNT_W'(MAX_SRC)
                                                     : cfgCount[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcCount <= '0;
      srcBase  <= '0;
    end else if (cfgWrite) begin
      srcCount <= clampedCount;
      srcBase  <= cfgBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldIdx <= '0;
      heldPe  <= '0;
    end else if (strobe.capture) begin
      heldIdx <= selIdx;
      heldPe  <= reqPe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      irqSrc   <= '0;
      irqNum   <= '0;
      errOob   <= 1'b0;
      errPe    <= 1'b0;
      rdReq    <= 1'b0;
    end else begin
      irqPulse <= strobe.emitIrq;
      errOob   <= strobe.emitOob;
      errPe    <= strobe.emitPeErr;
      rdReq    <= strobe.issueRd;
      if (strobe.emitIrq) begin
        irqSrc <= outIdx;
        irqNum <= srcBase + BASE_W'(outIdx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                injLock <= 1'b0;
    else if (strobe.dropLock) injLock <= 1'b0;
    else if (lockSet)         injLock <= 1'b1;
  end

endmodule

// File: rtl/msi_src_decoder.sv
module msi_src_decoder
  import msi_dec_pkg::*;
#(
  parameter int MAX_SRC = 2048,
  parameter int PE_W    = 8,
  parameter int BASE_W  = 24,
  parameter int CFG_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [CFG_W-1:0]  cfgCount,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [63:0]       reqAddr,
  input  logic [15:0]       reqData,
  input  logic              reqPeValid,
  input  logic [PE_W-1:0]   reqPe,
  input  logic              injValid,
  output logic              injReady,
  input  logic [63:0]       injValue,
  input  logic              lockSet,
  output logic              injLock,
  output logic              rdReq,
  output logic [15:0]       rdIdx,
  input  logic              rdValid,
  input  logic [PE_W-1:0]   rdPe,
  output logic              irqPulse,
  output logic [15:0]       irqSrc,
  output logic [BASE_W-1:0] irqNum,
  output logic              errOob,
  output logic              errPe
);

  ctl_strobe_t strobe;
  logic newInRange, peMatch;

  msi_dec_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPeValid (reqPeValid),
    .injValid   (injValid),
    .rdValid    (rdValid),
    .newInRange (newInRange),
    .peMatch    (peMatch),
    .reqReady   (reqReady),
    .injReady   (injReady),
    .strobe     (strobe)
  );

  msi_dec_dp #(
    .MAX_SRC (MAX_SRC),
    .PE_W    (PE_W),
    .BASE_W  (BASE_W),
    .CFG_W   (CFG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrite   (cfgWrite),
    .cfgBase    (cfgBase),
    .cfgCount   (cfgCount),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .reqPe      (reqPe),
    .injValue   (injValue),
    .lockSet    (lockSet),
    .rdPe       (rdPe),
    .newInRange (newInRange),
    .peMatch    (peMatch),
    .injLock    (injLock),
    .rdReq      (rdReq),
    .rdIdx      (rdIdx),
    .irqPulse   (irqPulse),
    .irqSrc     (irqSrc),
    .irqNum     (irqNum),
    .errOob     (errOob),
    .errPe      (errPe)
  );

endmodule

// File: rtl/msi_dec_checker.sv
module msi_dec_checker #(
  parameter int MAX_SRC = 2048
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        injReady,
  input logic        injValid,
  input logic        injLock,
  input logic        rdReq,
  input logic        irqPulse,
  input logic [15:0] irqSrc,
  input logic        errOob,
  input logic        errPe
);

  p_oob_no_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(irqPulse && errOob));

  p_pe_err_no_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(irqPulse && errPe));

  p_src_below_max_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (32'(irqSrc) < 32'(MAX_SRC)));

  p_rd_blocks_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (!reqReady && !injReady));

  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  p_inj_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> !reqReady);

  p_inj_drops_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && injReady) |=> !injLock);

endmodule

bind msi_src_decoder msi_dec_checker #(.MAX_SRC(MAX_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .injReady (injReady),
  .injValid (injValid),
  .injLock  (injLock),
  .rdReq    (rdReq),
  .irqPulse (irqPulse),
  .irqSrc   (irqSrc),
  .errOob   (errOob),
  .errPe    (errPe)
);

// File: tb/msi_src_decoder_bench.sv
module msi_src_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_SRC    = 64;
  localparam int PE_W       = 8;
  localparam int BASE_W     = 24;
  localparam int CFG_W      = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cfgWrite;
  logic [BASE_W-1:0] cfgBase;
  logic [CFG_W-1:0]  cfgCount;
  logic              reqValid, reqReady;
  logic [63:0]       reqAddr;
  logic [15:0]       reqData;
  logic              reqPeValid;
  logic [PE_W-1:0]   reqPe;
  logic              injValid, injReady;
  logic [63:0]       injValue;
  logic              lockSet, injLock;
  logic              rdReq;
  logic [15:0]       rdIdx;
  logic              rdValid;
  logic [PE_W-1:0]   rdPe;
  logic              irqPulse;
  logic [15:0]       irqSrc;
  logic [BASE_W-1:0] irqNum;
  logic              errOob, errPe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_src_decoder #(
    .MAX_SRC (MAX_SRC), .PE_W (PE_W), .BASE_W (BASE_W), .CFG_W (CFG_W)
  ) u_msi_src_decoder (
    .clk (clk), .rstN (rstN), .cfgWrite (cfgWrite), .cfgBase (cfgBase),
    .cfgCount (cfgCount), .reqValid (reqValid), .reqReady (reqReady),
    .reqAddr (reqAddr), .reqData (reqData), .reqPeValid (reqPeValid),
    .reqPe (reqPe), .injValid (injValid), .injReady (injReady),
    .injValue (injValue), .lockSet (lockSet), .injLock (injLock),
    .rdReq (rdReq), .rdIdx (rdIdx), .rdValid (rdValid), .rdPe (rdPe),
    .irqPulse (irqPulse), .irqSrc (irqSrc), .irqNum (irqNum),
    .errOob (errOob), .errPe (errPe)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic idleInputs();
    cfgWrite = 0; cfgBase = '0; cfgCount = '0;
    reqValid = 0; reqAddr = '0; reqData = '0; reqPeValid = 0; reqPe = '0;
    injValid = 0; injValue = '0; lockSet = 0; rdValid = 0; rdPe = '0;
  endtask

  // one accepted request; outputs sampled at the following negedge
  task automatic sendReq(input logic [63:0] a, input logic [15:0] d,
                         input logic peV, input logic [PE_W-1:0] pe);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqData = d; reqPeValid = peV; reqPe = pe;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0; reqPeValid = 0;
  endtask

  task automatic sendInj(input logic [63:0] v);
    @(negedge clk);
    injValid = 1; injValue = v;
    @(posedge clk);
    @(negedge clk);
    injValid = 0;
  endtask

  task automatic returnRead(input logic [PE_W-1:0] pe);
    @(negedge clk);
    rdValid = 1; rdPe = pe;
    @(posedge clk);
    @(negedge clk);
    rdValid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "irqPulse", irqPulse, 0);
    chk("R9", "errOob", errOob, 0);
    chk("R9", "errPe", errPe, 0);
    chk("R9", "rdReq", rdReq, 0);
    chk("R9", "injLock", injLock, 0);
    chk("R8", "injReady idle", injReady, 1);
    sendReq(64'h0, 16'h0, 0, 0);
    chk("R3", "count 0 rejects: errOob", errOob, 1);
    chk("R3", "count 0 rejects: irq", irqPulse, 0);
  endtask

  task automatic t_config();
    @(negedge clk);
    cfgWrite = 1; cfgBase = 24'h100; cfgCount = 100;
    @(posedge clk);
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic t_index();
    sendReq(64'h120, 16'h0005, 0, 0);
    chk("R4", "irqPulse", irqPulse, 1);
    chk("R1", "irqSrc 0x12|5", irqSrc, 16'h17);
    chk("R4", "irqNum", irqNum, 24'h117);
    @(negedge clk);
    chk("R4", "pulse one cycle", irqPulse, 0);
    sendReq(64'h30, 16'h001C, 0, 0);
    chk("R1", "irqSrc 3|1C", irqSrc, 16'h1F);
    sendReq(64'h200, 16'hFFE1, 0, 0);
    chk("R1", "high data bits ignored", irqSrc, 16'h21);
    sendReq(64'hFFFF_0000_0010_0000, 16'h0, 0, 0);
    chk("R1", "address above bit 19 ignored", irqSrc, 16'h0);
    chk("R1", "irq for index 0", irqPulse, 1);
  endtask

  task automatic t_bounds();
    sendReq(64'h3F0, 16'h0, 0, 0);
    chk("R2", "index 63 irq", irqPulse, 1);
    chk("R2", "index 63 no err", errOob, 0);
    sendReq(64'h400, 16'h0, 0, 0);
    chk("R3", "clamped count rejects 64", errOob, 1);
    chk("R2", "index 64 no irq", irqPulse, 0);
    sendReq(64'h400, 16'h0, 1, 8'h3);
    chk("R2", "oob with partition: no read", rdReq, 0);
    chk("R2", "oob with partition: errOob", errOob, 1);
  endtask

  task automatic t_pe_match();
    sendReq(64'hA0, 16'h0, 1, 8'h5);
    chk("R5", "rdReq", rdReq, 1);
    chk("R5", "rdIdx", rdIdx, 16'hA);
    chk("R5", "no early irq", irqPulse, 0);
    chk("R5", "reqReady low", reqReady, 0);
    chk("R8", "injReady low while waiting", injReady, 0);
    @(negedge clk);
    chk("R5", "rdReq single", rdReq, 0);
    chk("R5", "reqReady still low", reqReady, 0);
    returnRead(8'h5);
    chk("R6", "match irq", irqPulse, 1);
    chk("R6", "match irqSrc", irqSrc, 16'hA);
    chk("R6", "match no errPe", errPe, 0);
    chk("R5", "reqReady back", reqReady, 1);
  endtask

  task automatic t_pe_mismatch();
    sendReq(64'hB0, 16'h0, 1, 8'h5);
    chk("R5", "rdReq", rdReq, 1);
    returnRead(8'h6);
    chk("R6", "mismatch errPe", errPe, 1);
    chk("R6", "mismatch no irq", irqPulse, 0);
  endtask

  task automatic t_inject();
    @(negedge clk);
    lockSet = 1;
    @(posedge clk);
    @(negedge clk);
    lockSet = 0;
    chk("R9", "lockSet sets lock", injLock, 1);
    injValid = 1; injValue = 64'h50;
    reqValid = 1; reqAddr = 64'h70; reqPeValid = 0;
    #1;
    chk("R8", "reqReady low under injection", reqReady, 0);
    @(posedge clk);
    @(negedge clk);
    injValid = 0; reqValid = 0;
    chk("R7", "inj irq", irqPulse, 1);
    chk("R7", "inj irqSrc", irqSrc, 16'h5);
    chk("R7", "inj no read", rdReq, 0);
    chk("R7", "lock cleared", injLock, 0);
    @(negedge clk);
    lockSet = 1;
    @(posedge clk);
    @(negedge clk);
    lockSet = 0;
    sendInj(64'h800);
    chk("R7", "inj oob errOob", errOob, 1);
    chk("R7", "inj oob no irq", irqPulse, 0);
    chk("R7", "inj oob lock cleared", injLock, 0);
  endtask

  task automatic t_stray_read();
    returnRead(8'h0);
    chk("R10", "stray rdValid no irq", irqPulse, 0);
    chk("R10", "stray rdValid no errPe", errPe, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_config();
    t_index();
    t_bounds();
    t_pe_match();
    t_pe_mismatch();
    t_inject();
    t_stray_read();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule